// File: doc/BRIEF.md
# Early-Late Sampling Point Adjustment Controller

This block decides, once per received symbol, whether a demodulator should shift its sampling instant by one step toward earlier or later samples. On every symbol strobe it looks at the accumulated early and late correlation sums, the measured signal strength, a matched-filter average and the packet-phase flags. It then issues a single-cycle advance or retard pulse, or no pulse at all. The correlators, matched filter and strength estimator sit outside the block. Their results arrive as plain numbers.

Static controls choose four things. The first is whether both sums or either sum must clear the correlation threshold. The second is whether correction runs at a slow, counted rate after the access address matches, or only before that match. The third is whether correction stops when the preamble ends. The fourth is whether the matched-filter average must also clear its own threshold. Two registered direction indications record the last early/late comparison that cleared the threshold.

Top module: `el_adjust_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both pulse outputs, both direction indications and the slow-track counter.
- R2: With `cmp_both` = 1, the threshold test passes only when `early_sum` > `el_thresh` and `late_sum` > `el_thresh`, both strictly greater.
- R3: With `cmp_both` = 0, the threshold test passes when at least one of the two sums is strictly greater than `el_thresh`.
- R4: A qualified adjustment drives `adv_o` when `early_sum` > `late_sum` and drives `ret_o` otherwise, including when the two sums are equal. The two outputs are never high in the same cycle.
- R5: Decisions are taken only at a clock edge where `sym_stb` = 1. The resulting pulse is high for exactly the cycle after that edge. Without a strobe, no pulse appears.
- R6: `fwd_ind`/`bwd_ind` are updated at a strobe edge where the threshold test passes (`fwd_ind` = 1 when early > late, `bwd_ind` = its complement). At any other edge they hold their value.
- R7: No pulse is issued unless `rssi` > `rssi_floor` (strict). Any 7-bit floor value from 0x00 to 0x7F is accepted, so a floor of 0x7F blocks every adjustment.
- R8: With `mf_gate_en` = 1, an adjustment also needs `mf_avg` > `mf_thresh`. With `mf_gate_en` = 0, the matched-filter values have no effect.
- R9: With `slow_en` = 0, adjustments happen only while `aa_matched` = 0.
- R10: With `slow_en` = 1, adjustments happen only while `aa_matched` = 1, and only at a strobe where the slow-track counter equals `slow_thresh`. The counter advances by one on each strobe while `aa_matched` = 1, and returns to 0 on the strobe where it equals `slow_thresh`. With threshold N, every (N+1)-th strobe adjusts.
- R11: `pkt_start` = 1 at an edge clears the slow-track counter. This takes priority over counting.
- R12: With `full_pkt_off` = 1, adjustments happen only while `in_preamble` = 1. With `full_pkt_off` = 0, the preamble flag has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_stb | input | 1 | Symbol strobe; decisions are taken only when it is high |
| early_sum | input | SUM_W (16) | Accumulated early correlation sum |
| late_sum | input | SUM_W (16) | Accumulated late correlation sum |
| el_thresh | input | SUM_W (16) | Correlation threshold |
| rssi | input | RSSI_W (7) | Measured signal strength |
| rssi_floor | input | RSSI_W (7) | Minimum strength required for adjustment |
| mf_avg | input | MF_W (12) | Matched-filter average |
| mf_thresh | input | MF_W (12) | Matched-filter threshold |
| pkt_start | input | 1 | Start of a new packet; clears the slow counter |
| in_preamble | input | 1 | High while the preamble is being received |
| aa_matched | input | 1 | High once the access address has matched |
| cmp_both | input | 1 | 1: both sums must exceed threshold; 0: either sum |
| slow_en | input | 1 | 1: slow counted tracking after address match |
| full_pkt_off | input | 1 | 1: restrict adjustment to the preamble |
| mf_gate_en | input | 1 | 1: also require the matched-filter threshold |
| slow_thresh | input | CNT_W (4) | Slow-track counter compare value |
| adv_o | output | 1 | One-cycle pulse: move sampling point earlier |
| ret_o | output | 1 | One-cycle pulse: move sampling point later |
| fwd_ind | output | 1 | Last qualified comparison favoured early |
| bwd_ind | output | 1 | Last qualified comparison favoured late |

## Verification
The hardest case to reach is the slow-tracking cadence. Its counter is invisible at the ports and advances only on strobes after the address match. It is seen only through which strobe finally produces a pulse. The stimulus runs long strobe trains with all other gates held open. It cuts one train with `pkt_start` part-way through and another with a reset. It also lowers the compare value below the current count, which forces the counter through its natural wrap. A behavioural model that tracks the count as an integer predicts the exact strobe that must fire in each case.

// File: rtl/el_adj_pkg.sv
package el_adj_pkg;

    // Registered outputs of the controller
    typedef struct packed {
        logic adv;   // advance pulse
        logic ret;   // retard pulse
        logic fwd;   // direction indication: early led
        logic bwd;   // direction indication: late led
    } el_out_t;

    localparam int unsigned N_SUMS = 2;

endpackage

// File: rtl/el_thr_eval.sv
module el_thr_eval #(
    parameter int unsigned SUM_W  = 16,
    parameter int unsigned RSSI_W = 7,
    parameter int unsigned MF_W   = 12
) (
    input  logic [SUM_W-1:0]  early_sum,
    input  logic [SUM_W-1:0]  late_sum,
    input  logic [SUM_W-1:0]  el_thresh,
    input  logic [RSSI_W-1:0] rssi,
    input  logic [RSSI_W-1:0] rssi_floor,
    input  logic [MF_W-1:0]   mf_avg,
    input  logic [MF_W-1:0]   mf_thresh,
    input  logic              cmp_both,
    input  logic              mf_gate_en,
    output logic              thr_met,
    output logic              gates_ok,
    output logic              early_lead
);
    import el_adj_pkg::*;

    logic [SUM_W-1:0]  sums [N_SUMS];
    logic [N_SUMS-1:0] over;
    logic              rssi_ok;
    logic              mf_ok;

    assign sums[0] = early_sum;
    assign sums[1] = late_sum;

    // one strict comparator per correlation sum
    for (genvar g = 0; g < N_SUMS; g++) begin : g_cmp
        assign over[g] = sums[g] > el_thresh;
    end

    always_comb begin
        thr_met    = cmp_both ? (&over) : (|over);
        rssi_ok    = rssi > rssi_floor;
        mf_ok      = !mf_gate_en || (mf_avg > mf_thresh);
        gates_ok   = rssi_ok && mf_ok;
        early_lead = early_sum > late_sum;
    end

endmodule

// File: rtl/el_phase_gate.sv
module el_phase_gate #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sym_stb,
    input  logic             pkt_start,
    input  logic             aa_matched,
    input  logic             in_preamble,
    input  logic             slow_en,
    input  logic             full_pkt_off,
    input  logic [CNT_W-1:0] slow_thresh,
    output logic             phase_ok
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pg_state_t;

    pg_state_t st_d, st_q;
    logic      hit;
    logic      region_ok;

    always_comb begin
        st_d = st_q;
        hit  = (st_q.cnt == slow_thresh);
        if (pkt_start) begin
            st_d.cnt = CNT_ZERO;
        end else if (sym_stb && aa_matched) begin
            st_d.cnt = hit ? CNT_ZERO : st_q.cnt + CNT_ONE;
        end
        region_ok = full_pkt_off ? in_preamble : 1'b1;
        if (slow_en) begin
            phase_ok = region_ok && aa_matched && hit;
        end else begin
            phase_ok = region_ok && !aa_matched;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
        $past(pkt_start) && !$past(rst) |-> st_q.cnt == CNT_ZERO) // R11
        else $error("counter not cleared at packet start");

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst || pkt_start)
        sym_stb && aa_matched && !hit |=> st_q.cnt != CNT_ZERO || $past(st_q.cnt) == {CNT_W{1'b1}}) // R10
        else $error("counter failed to advance");

endmodule

// File: rtl/el_adjust_ctrl.sv
module el_adjust_ctrl #(
    parameter int unsigned SUM_W  = 16,
    parameter int unsigned RSSI_W = 7,
    parameter int unsigned MF_W   = 12,
    parameter int unsigned CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sym_stb,
    input  logic [SUM_W-1:0]  early_sum,
    input  logic [SUM_W-1:0]  late_sum,
    input  logic [SUM_W-1:0]  el_thresh,
    input  logic [RSSI_W-1:0] rssi,
    input  logic [RSSI_W-1:0] rssi_floor,
    input  logic [MF_W-1:0]   mf_avg,
    input  logic [MF_W-1:0]   mf_thresh,
    input  logic              pkt_start,
    input  logic              in_preamble,
    input  logic              aa_matched,
    input  logic              cmp_both,
    input  logic              slow_en,
    input  logic              full_pkt_off,
    input  logic              mf_gate_en,
    input  logic [CNT_W-1:0]  slow_thresh,
    output logic              adv_o,
    output logic              ret_o,
    output logic              fwd_ind,
    output logic              bwd_ind
);
    import el_adj_pkg::*;

    logic    thr_met, gates_ok, early_lead, phase_ok, fire;
    el_out_t out_d, out_q;
    logic    live_q;

    el_thr_eval #(.SUM_W(SUM_W), .RSSI_W(RSSI_W), .MF_W(MF_W)) u_eval (
        .early_sum (early_sum),
        .late_sum  (late_sum),
        .el_thresh (el_thresh),
        .rssi      (rssi),
        .rssi_floor(rssi_floor),
        .mf_avg    (mf_avg),
        .mf_thresh (mf_thresh),
        .cmp_both  (cmp_both),
        .mf_gate_en(mf_gate_en),
        .thr_met   (thr_met),
        .gates_ok  (gates_ok),
        .early_lead(early_lead)
    );

    el_phase_gate #(.CNT_W(CNT_W)) u_phase (
        .clk         (clk),
        .rst         (rst),
        .sym_stb     (sym_stb),
        .pkt_start   (pkt_start),
        .aa_matched  (aa_matched),
        .in_preamble (in_preamble),
        .slow_en     (slow_en),
        .full_pkt_off(full_pkt_off),
        .slow_thresh (slow_thresh),
        .phase_ok    (phase_ok)
    );

    always_comb begin
        out_d     = out_q;
        fire      = sym_stb && thr_met && gates_ok && phase_ok;
        out_d.adv = fire && early_lead;
        out_d.ret = fire && !early_lead;
        if (sym_stb && thr_met) begin
            out_d.fwd = early_lead;
            out_d.bwd = !early_lead;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            live_q <= 1'b0;
        end else begin
            out_q  <= out_d;
            live_q <= 1'b1;
        end
    end

    assign adv_o   = out_q.adv;
    assign ret_o   = out_q.ret;
    assign fwd_ind = out_q.fwd;
    assign bwd_ind = out_q.bwd;

    AST_ADV_RET_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(adv_o && ret_o)) // R4
        else $error("advance and retard together");

    AST_PULSE_NEEDS_STB: assert property (@(posedge clk) disable iff (rst)
        live_q && (adv_o || ret_o) |-> $past(sym_stb)) // R5
        else $error("pulse without strobe");

    AST_RSSI_FLOOR: assert property (@(posedge clk) disable iff (rst)
        live_q && (adv_o || ret_o) |-> $past(rssi) > $past(rssi_floor)) // R7
        else $error("pulse below strength floor");

    AST_FAST_BEFORE_AA: assert property (@(posedge clk) disable iff (rst)
        live_q && (adv_o || ret_o) && !$past(slow_en) |-> !$past(aa_matched)) // R9
        else $error("fast adjustment after address match");

    AST_SLOW_AFTER_AA: assert property (@(posedge clk) disable iff (rst)
        live_q && (adv_o || ret_o) && $past(slow_en) |-> $past(aa_matched)) // R10
        else $error("slow adjustment before address match");

    AST_IND_HOLD: assert property (@(posedge clk) disable iff (rst)
        live_q && !$past(sym_stb) && !$past(rst) |-> $stable(fwd_ind) && $stable(bwd_ind)) // R6
        else $error("indication moved without strobe");

    AST_PREAMBLE_ONLY: assert property (@(posedge clk) disable iff (rst)
        live_q && (adv_o || ret_o) && $past(full_pkt_off) |-> $past(in_preamble)) // R12
        else $error("adjustment outside preamble");

endmodule

// File: tb/sim_el_adjust_ctrl.sv
module sim_el_adjust_ctrl;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sym_stb = 1'b0;
    logic [15:0] early_sum = '0, late_sum = '0, el_thresh = 16'd100;
    logic [6:0]  rssi = 7'd50, rssi_floor = 7'd20;
    logic [11:0] mf_avg = '0, mf_thresh = 12'd40;
    logic        pkt_start = 1'b0, in_preamble = 1'b1, aa_matched = 1'b0;
    logic        cmp_both = 1'b0, slow_en = 1'b0, full_pkt_off = 1'b0, mf_gate_en = 1'b0;
    logic [3:0]  slow_thresh = 4'd3;
    logic        adv_o, ret_o, fwd_ind, bwd_ind;

    int    checks = 0, failures = 0, adv_cnt = 0;
    string cur = "R1";
    bit    done = 0;

    // behavioural model state
    int m_cnt = 0;
    bit m_adv = 0, m_ret = 0, m_fwd = 0, m_bwd = 0;

    always #(CLK_P/2) clk = ~clk;

    el_adjust_ctrl u0 (
        .clk(clk), .rst(rst), .sym_stb(sym_stb), .early_sum(early_sum), .late_sum(late_sum),
        .el_thresh(el_thresh), .rssi(rssi), .rssi_floor(rssi_floor), .mf_avg(mf_avg),
        .mf_thresh(mf_thresh), .pkt_start(pkt_start), .in_preamble(in_preamble),
        .aa_matched(aa_matched), .cmp_both(cmp_both), .slow_en(slow_en),
        .full_pkt_off(full_pkt_off), .mf_gate_en(mf_gate_en), .slow_thresh(slow_thresh),
        .adv_o(adv_o), .ret_o(ret_o), .fwd_ind(fwd_ind), .bwd_ind(bwd_ind)
    );

    always @(posedge clk) begin
        bit e_over, l_over, thr, ok, lead, hit;
        if (rst) begin
            m_cnt = 0; m_adv = 0; m_ret = 0; m_fwd = 0; m_bwd = 0;
        end else begin
            e_over = int'(early_sum) > int'(el_thresh);
            l_over = int'(late_sum) > int'(el_thresh);
            thr    = cmp_both ? (e_over && l_over) : (e_over || l_over);
            lead   = int'(early_sum) > int'(late_sum);
            hit    = (m_cnt == int'(slow_thresh));
            ok     = sym_stb && thr && (int'(rssi) > int'(rssi_floor));
            if (mf_gate_en && !(int'(mf_avg) > int'(mf_thresh))) ok = 0;
            if (full_pkt_off && !in_preamble) ok = 0;
            if (slow_en) ok = ok && aa_matched && hit;
            else         ok = ok && !aa_matched;
            m_adv = ok && lead;
            m_ret = ok && !lead;
            if (sym_stb && thr) begin m_fwd = lead; m_bwd = !lead; end
            if (pkt_start) m_cnt = 0;
            else if (sym_stb && aa_matched) m_cnt = hit ? 0 : (m_cnt + 1) % 16;
        end
    end

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        chk(cur, "adv_o", adv_o, m_adv);
        chk(cur, "ret_o", ret_o, m_ret);
        chk(cur, "fwd_ind", fwd_ind, m_fwd);
        chk(cur, "bwd_ind", bwd_ind, m_bwd);
        if (adv_o) adv_cnt++;
    endtask

    task automatic stb(int e, int l);
        early_sum = 16'(e); late_sum = 16'(l); sym_stb = 1'b1;
        tick();
        sym_stb = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "adv_o reset", adv_o, 1'b0);
        chk("R1", "ret_o reset", ret_o, 1'b0);
        chk("R1", "fwd_ind reset", fwd_ind, 1'b0);
        chk("R1", "bwd_ind reset", bwd_ind, 1'b0);
        tick();

        // R3: either mode
        cur = "R3"; cmp_both = 0;
        stb(50, 150); tick(); stb(150, 50); tick(); stb(50, 50); tick(); stb(100, 101);
        chk("R3", "ret after late>thr", ret_o, 1'b1);

        // R2: both mode, strict
        cur = "R2"; cmp_both = 1;
        stb(150, 50); chk("R2", "no pulse one sum", adv_o | ret_o, 1'b0);
        stb(150, 120); chk("R2", "adv both over", adv_o, 1'b1);
        stb(100, 200); stb(101, 101);

        // R4: direction and tie
        cur = "R4"; cmp_both = 0;
        stb(150, 150); chk("R4", "tie gives retard", ret_o, 1'b1);
        stb(151, 150); stb(0, 300);

        // R5: pulse width and strobe dependence
        cur = "R5";
        early_sum = 16'd300; late_sum = 16'd0; sym_stb = 1'b0;
        tick(); chk("R5", "no strobe no pulse", adv_o, 1'b0);
        sym_stb = 1'b1; tick(); tick(); sym_stb = 1'b0;
        tick(); chk("R5", "pulse ends", adv_o, 1'b0);

        // R6: indications hold when threshold fails
        cur = "R6";
        stb(300, 0); stb(10, 20); chk("R6", "fwd held", fwd_ind, 1'b1);
        stb(20, 300); chk("R6", "bwd updated", bwd_ind, 1'b1);

        // R7: strength floor
        cur = "R7";
        rssi_floor = 7'h00; rssi = 7'h01; stb(300, 0);
        rssi = 7'h00; stb(300, 0); chk("R7", "equal strength blocks", adv_o, 1'b0);
        rssi_floor = 7'h7F; rssi = 7'h7F; stb(300, 0);
        chk("R7", "max floor blocks", adv_o, 1'b0);
        rssi_floor = 7'h3F; rssi = 7'h40; stb(300, 0);
        rssi_floor = 7'd20; rssi = 7'd50;

        // R8: matched-filter gate
        cur = "R8";
        mf_gate_en = 1; mf_avg = 12'd40; stb(300, 0);
        chk("R8", "mf equal blocks", adv_o, 1'b0);
        mf_avg = 12'd41; stb(300, 0);
        mf_gate_en = 0; mf_avg = 12'd0; stb(300, 0);
        chk("R8", "mf ignored", adv_o, 1'b1);

        // R12: preamble restriction
        cur = "R12";
        full_pkt_off = 1; in_preamble = 0; stb(300, 0);
        chk("R12", "blocked after preamble", adv_o, 1'b0);
        in_preamble = 1; stb(300, 0);
        full_pkt_off = 0; in_preamble = 0; stb(300, 0);
        chk("R12", "payload tracked", adv_o, 1'b1);

        // R9: fast mode only before address match
        cur = "R9";
        aa_matched = 1; stb(300, 0); chk("R9", "blocked after match", adv_o, 1'b0);
        stb(0, 300);

        // R10: slow cadence, threshold 3 -> every 4th strobe
        cur = "R10";
        pkt_start = 1; tick(); pkt_start = 0;
        slow_en = 1; slow_thresh = 4'd3; adv_cnt = 0;
        for (int i = 0; i < 12; i++) begin stb(300, 0); tick(); end
        chk("R10", "3 pulses in 12 strobes", adv_cnt == 3, 1'b1);
        aa_matched = 0; stb(300, 0); aa_matched = 1;
        slow_thresh = 4'd0;
        for (int i = 0; i < 3; i++) stb(300, 0);
        slow_thresh = 4'd6;
        for (int i = 0; i < 4; i++) stb(300, 0);
        slow_thresh = 4'd2;
        for (int i = 0; i < 20; i++) stb(300, 0);

        // R11: packet start clears counter mid-count
        cur = "R11";
        slow_thresh = 4'd3;
        pkt_start = 1; tick(); pkt_start = 0;
        stb(300, 0); stb(300, 0);
        pkt_start = 1; tick(); pkt_start = 0;
        adv_cnt = 0;
        for (int i = 0; i < 4; i++) stb(300, 0);
        chk("R11", "restart cadence", adv_cnt == 1, 1'b1);
        sym_stb = 1; early_sum = 16'd300; pkt_start = 1; tick(); pkt_start = 0; sym_stb = 0;
        for (int i = 0; i < 5; i++) stb(300, 0);

        // R1: reset mid-count restarts the cadence
        cur = "R1";
        stb(300, 0); stb(300, 0);
        rst = 1; tick(); rst = 0;
        chk("R1", "indication cleared", fwd_ind, 1'b0);
        for (int i = 0; i < 6; i++) stb(300, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule